// File: doc/BRIEF.md
# Free-List Register Rename Unit

This block translates the architectural register names of one instruction per cycle into physical register names. It keeps a table with one entry per logical register, giving the physical register that currently holds that register's value, and a circular queue of the physical registers that no instruction owns. The physical register space is larger than the logical one, so a destination can always be given a fresh register while older consumers still read the previous one.

On a rename request both source names are looked up in the table. If the instruction writes a register, a physical register is taken from the head of the free queue, and the table entry for the destination is pointed at it on the next clock edge. The physical register that the destination mapped to before the rename is also reported. A later commit stage hands that register back through the release input, and it joins the tail of the free queue. When no free register is left, the block withholds its ready signal and changes nothing.

Lookups and the allocated register are combinational from the state held at the start of the cycle. Table and queue updates take effect at the next rising clock edge.

Top module: `rename_unit`

## Requirements
- R1: After reset, logical register i maps to physical register i for every i in 0..7, and the free queue holds physical registers 8 to 15, so the first eight allocations return 8, 9, ..., 15 in that order.
- R2: For a request, src_a_phys_o and src_b_phys_o give the table entries of ren_src_a_i and ren_src_b_i as they stand at the start of that cycle.
- R3: When a source names the same logical register as the destination, the source returns the mapping held before this instruction's rename, not the newly allocated register.
- R4: After an accepted rename with a destination, a later lookup of that logical register returns the physical register reported on dst_phys_o for that rename.
- R5: dst_prev_phys_o gives the mapping of the destination logical register before the rename, and differs from the newly allocated register.
- R6: Allocations leave the free queue in first-in, first-out order: released registers are handed out after every register that was already queued.
- R7: When the free queue is empty and a request needs a destination, ren_ready_o is low, no register is allocated, and the table is left unchanged.
- R8: A release and an allocation in the same cycle are both accepted; the released register is appended at the tail while the allocation takes the head.
- R9: A release arriving when the free queue already holds 8 registers, with no allocation in that cycle, is dropped.
- R10: A request with ren_dst_en_i low is always ready, allocates nothing and changes no table entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| ren_valid_i | input | 1 | A rename request is present |
| ren_src_a_i | input | 3 | First source logical register |
| ren_src_b_i | input | 3 | Second source logical register |
| ren_dst_i | input | 3 | Destination logical register |
| ren_dst_en_i | input | 1 | The instruction writes ren_dst_i |
| ren_ready_o | output | 1 | Request can be accepted this cycle |
| src_a_phys_o | output | 4 | Physical register for the first source |
| src_b_phys_o | output | 4 | Physical register for the second source |
| dst_phys_o | output | 4 | Physical register allocated to the destination |
| dst_prev_phys_o | output | 4 | Physical register the destination mapped to before the rename |
| rel_valid_i | input | 1 | Return a physical register to the free queue |
| rel_phys_i | input | 4 | Physical register being returned |

## Verification
The hardest situation to reach is the free queue wrapping around while allocations and releases interleave, including a release landing in the same cycle as an allocation when the queue holds a single register. The stimulus first drains the queue completely through eight back-to-back renames, probes the empty state, then refills it one register at a time with a simultaneous allocation. It continues with a long stretch of random requests whose releases are drawn only from previously displaced registers, so the head and tail pointers wrap many times and the queue occupancy moves between empty and nearly full.

// File: rtl/rename_pkg.sv
package rename_pkg;

    localparam int unsigned LOG_REGS_DEF  = 8;
    localparam int unsigned PHYS_REGS_DEF = 16;

endpackage

// File: rtl/rename_map_table.sv
module rename_map_table
    import rename_pkg::*;
#(
    parameter int unsigned NUM_LOG  = LOG_REGS_DEF,
    parameter int unsigned NUM_PHYS = PHYS_REGS_DEF,
    parameter int unsigned NUM_RD   = 3,
    localparam int unsigned LW = $clog2(NUM_LOG),
    localparam int unsigned PW = $clog2(NUM_PHYS)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NUM_RD-1:0][LW-1:0] rd_idx_i,
    output logic [NUM_RD-1:0][PW-1:0] rd_phys_o,
    input  logic                     wr_en_i,
    input  logic [LW-1:0]            wr_idx_i,
    input  logic [PW-1:0]            wr_phys_i
);

    typedef struct packed {
        logic [NUM_LOG-1:0][PW-1:0] ent;
    } table_t;

    table_t tbl_d, tbl_q;

    function automatic table_t reset_table();
        table_t t;
        for (int i = 0; i < int'(NUM_LOG); i++) begin
            t.ent[i] = PW'(i);
        end
        return t;
    endfunction

    always_comb begin
        tbl_d = tbl_q;
        if (wr_en_i) begin
            tbl_d.ent[wr_idx_i] = wr_phys_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tbl_q <= reset_table();
        end else begin
            tbl_q <= tbl_d;
        end
    end

    for (genvar g = 0; g < int'(NUM_RD); g++) begin : g_rd
        assign rd_phys_o[g] = tbl_q.ent[rd_idx_i[g]];
    end

endmodule

// File: rtl/rename_free_fifo.sv
module rename_free_fifo
    import rename_pkg::*;
#(
    parameter int unsigned NUM_LOG  = LOG_REGS_DEF,
    parameter int unsigned NUM_PHYS = PHYS_REGS_DEF,
    localparam int unsigned DEPTH = NUM_PHYS - NUM_LOG,
    localparam int unsigned PW    = $clog2(NUM_PHYS),
    localparam int unsigned IW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int unsigned CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pop_i,
    input  logic          push_i,
    input  logic [PW-1:0] push_phys_i,
    output logic [PW-1:0] head_phys_o,
    output logic          empty_o
);

    typedef struct packed {
        logic [DEPTH-1:0][PW-1:0] slot;
        logic [IW-1:0]            head;
        logic [IW-1:0]            tail;
        logic [CW-1:0]            count;
    } fifo_t;

    fifo_t st_d, st_q;
    logic  do_pop, do_push;

    function automatic logic [IW-1:0] ptr_inc(logic [IW-1:0] p);
        if (p == IW'(DEPTH - 1)) begin
            return '0;
        end
        return p + IW'(1);
    endfunction

    function automatic fifo_t reset_fifo();
        fifo_t f;
        for (int i = 0; i < int'(DEPTH); i++) begin
            f.slot[i] = PW'(int'(NUM_LOG) + i);
        end
        f.head  = '0;
        f.tail  = '0;
        f.count = CW'(DEPTH);
        return f;
    endfunction

    always_comb begin
        st_d    = st_q;
        do_pop  = pop_i && (st_q.count != '0);
        do_push = push_i && ((st_q.count != CW'(DEPTH)) || do_pop);
        if (do_pop) begin
            st_d.head = ptr_inc(st_q.head);
        end
        if (do_push) begin
            st_d.slot[st_q.tail] = push_phys_i;
            st_d.tail            = ptr_inc(st_q.tail);
        end
        case ({do_push, do_pop})
            2'b10:   st_d.count = st_q.count + CW'(1);
            2'b01:   st_d.count = st_q.count - CW'(1);
            default: st_d.count = st_q.count;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= reset_fifo();
        end else begin
            st_q <= st_d;
        end
    end

    assign head_phys_o = st_q.slot[st_q.head];
    assign empty_o     = (st_q.count == '0);

endmodule

// File: rtl/rename_unit.sv
module rename_unit
    import rename_pkg::*;
#(
    parameter int unsigned NUM_LOG  = LOG_REGS_DEF,
    parameter int unsigned NUM_PHYS = PHYS_REGS_DEF,
    localparam int unsigned LW = $clog2(NUM_LOG),
    localparam int unsigned PW = $clog2(NUM_PHYS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ren_valid_i,
    input  logic [LW-1:0] ren_src_a_i,
    input  logic [LW-1:0] ren_src_b_i,
    input  logic [LW-1:0] ren_dst_i,
    input  logic          ren_dst_en_i,
    output logic          ren_ready_o,
    output logic [PW-1:0] src_a_phys_o,
    output logic [PW-1:0] src_b_phys_o,
    output logic [PW-1:0] dst_phys_o,
    output logic [PW-1:0] dst_prev_phys_o,
    input  logic          rel_valid_i,
    input  logic [PW-1:0] rel_phys_i
);

    localparam int unsigned NUM_RD = 3;

    logic                      free_empty;
    logic                      alloc;
    logic [PW-1:0]             free_head;
    logic [NUM_RD-1:0][LW-1:0] rd_idx;
    logic [NUM_RD-1:0][PW-1:0] rd_phys;

    // sources and the old destination mapping come from the pre-update table
    assign rd_idx      = {ren_dst_i, ren_src_b_i, ren_src_a_i};
    assign ren_ready_o = !free_empty || !ren_dst_en_i;
    assign alloc       = ren_valid_i && ren_dst_en_i && !free_empty;

    rename_map_table #(
        .NUM_LOG  (NUM_LOG),
        .NUM_PHYS (NUM_PHYS),
        .NUM_RD   (NUM_RD)
    ) u_map (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_idx_i  (rd_idx),
        .rd_phys_o (rd_phys),
        .wr_en_i   (alloc),
        .wr_idx_i  (ren_dst_i),
        .wr_phys_i (free_head)
    );

    rename_free_fifo #(
        .NUM_LOG  (NUM_LOG),
        .NUM_PHYS (NUM_PHYS)
    ) u_free (
        .clk         (clk),
        .rst_n       (rst_n),
        .pop_i       (alloc),
        .push_i      (rel_valid_i),
        .push_phys_i (rel_phys_i),
        .head_phys_o (free_head),
        .empty_o     (free_empty)
    );

    assign src_a_phys_o    = rd_phys[0];
    assign src_b_phys_o    = rd_phys[1];
    assign dst_prev_phys_o = rd_phys[2];
    assign dst_phys_o      = free_head;

endmodule

// File: rtl/rename_unit_chk.sv
module rename_unit_chk #(
    parameter int unsigned LW = 3,
    parameter int unsigned PW = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          ren_valid_i,
    input logic [LW-1:0] ren_src_a_i,
    input logic [LW-1:0] ren_dst_i,
    input logic          ren_dst_en_i,
    input logic          ren_ready_o,
    input logic [PW-1:0] src_a_phys_o,
    input logic [PW-1:0] dst_phys_o,
    input logic [PW-1:0] dst_prev_phys_o,
    input logic          rel_valid_i
);

    assert_src_alias_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ren_valid_i && ren_src_a_i == ren_dst_i) |-> (src_a_phys_o == dst_prev_phys_o));

    assert_map_visible_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ren_valid_i && ren_ready_o && ren_dst_en_i) |=>
        (ren_src_a_i != $past(ren_dst_i) || src_a_phys_o == $past(dst_phys_o)));

    assert_fresh_dst_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ren_valid_i && ren_ready_o && ren_dst_en_i) |-> (dst_phys_o != dst_prev_phys_o));

    assert_stall_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ren_valid_i && ren_dst_en_i && !ren_ready_o && !rel_valid_i) |=>
        (!ren_dst_en_i || !ren_ready_o));

    assert_nodst_ready_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !ren_dst_en_i |-> ren_ready_o);

endmodule

bind rename_unit rename_unit_chk #(.LW(LW), .PW(PW)) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .ren_valid_i     (ren_valid_i),
    .ren_src_a_i     (ren_src_a_i),
    .ren_dst_i       (ren_dst_i),
    .ren_dst_en_i    (ren_dst_en_i),
    .ren_ready_o     (ren_ready_o),
    .src_a_phys_o    (src_a_phys_o),
    .dst_phys_o      (dst_phys_o),
    .dst_prev_phys_o (dst_prev_phys_o),
    .rel_valid_i     (rel_valid_i)
);

// File: tb/rename_unit_bench.sv
module rename_unit_bench;

    localparam int CLK_PERIOD = 10;
    localparam int NLOG  = 8;
    localparam int DEPTH = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ren_valid_i = 1'b0;
    logic [2:0] ren_src_a_i = '0;
    logic [2:0] ren_src_b_i = '0;
    logic [2:0] ren_dst_i = '0;
    logic       ren_dst_en_i = 1'b0;
    logic       ren_ready_o;
    logic [3:0] src_a_phys_o, src_b_phys_o, dst_phys_o, dst_prev_phys_o;
    logic       rel_valid_i = 1'b0;
    logic [3:0] rel_phys_i = '0;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    int model_map [NLOG];
    int freeq [$];
    int pend [$];

    int s_ready, s_a, s_b, s_dst, s_prev;

    always #(CLK_PERIOD/2) clk = ~clk;

    rename_unit u_rename_unit (
        .clk             (clk),
        .rst_n           (rst_n),
        .ren_valid_i     (ren_valid_i),
        .ren_src_a_i     (ren_src_a_i),
        .ren_src_b_i     (ren_src_b_i),
        .ren_dst_i       (ren_dst_i),
        .ren_dst_en_i    (ren_dst_en_i),
        .ren_ready_o     (ren_ready_o),
        .src_a_phys_o    (src_a_phys_o),
        .src_b_phys_o    (src_b_phys_o),
        .dst_phys_o      (dst_phys_o),
        .dst_prev_phys_o (dst_prev_phys_o),
        .rel_valid_i     (rel_valid_i),
        .rel_phys_i      (rel_phys_i)
    );

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    // one cycle: drive at negedge, compare against model, advance model
    task automatic step(bit v, int sa, int sb, int d, bit de, bit rl, int rp);
        bit exp_ready;
        @(negedge clk);
        ren_valid_i  = v;
        ren_src_a_i  = 3'(sa);
        ren_src_b_i  = 3'(sb);
        ren_dst_i    = 3'(d);
        ren_dst_en_i = de;
        rel_valid_i  = rl;
        rel_phys_i   = 4'(rp);
        #1;
        s_ready = int'(ren_ready_o);
        s_a     = int'(src_a_phys_o);
        s_b     = int'(src_b_phys_o);
        s_dst   = int'(dst_phys_o);
        s_prev  = int'(dst_prev_phys_o);
        exp_ready = (freeq.size() != 0) || !de;
        check(de ? "R7 ready" : "R10 ready", s_ready, int'(exp_ready));
        if (v) begin
            check("R2 src_a", s_a, model_map[sa]);
            check("R2 src_b", s_b, model_map[sb]);
        end
        if (v && de && exp_ready) begin
            check("R6 dst", s_dst, freeq[0]);
            check("R5 prev", s_prev, model_map[d]);
            pend.push_back(model_map[d]);
            model_map[d] = freeq.pop_front();
        end
        if (rl && freeq.size() < DEPTH) begin
            freeq.push_back(rp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        int a_reg, b_reg, keep;
        for (int i = 0; i < NLOG; i++) model_map[i] = i;
        for (int i = 0; i < DEPTH; i++) freeq.push_back(NLOG + i);
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: identity map after reset
        for (int i = 0; i < NLOG; i++) begin
            step(1, i, NLOG - 1 - i, 0, 0, 0, 0);
            check("R1 map_a", s_a, i);
            check("R1 map_b", s_b, NLOG - 1 - i);
        end

        // R9: release into a full queue is dropped (phys 3 is still mapped)
        step(0, 0, 0, 0, 0, 1, 3);

        // drain: ascending allocation, first one aliases source and dest
        for (int i = 0; i < DEPTH; i++) begin
            step(1, 3, 1, (i + 3) % NLOG, 1, 0, 0);
            check("R1 alloc order", s_dst, NLOG + i);
            if (i == 0) check("R3 alias old", s_a, s_prev);
        end
        // R4: r3 now reads the register allocated to it
        step(1, 3, 4, 0, 0, 0, 0);
        check("R4 new map r3", s_a, 8);
        check("R4 new map r4", s_b, 9);

        // R7 / R9: queue is empty, the dropped release did not refill it
        keep = model_map[2];
        step(1, 0, 0, 2, 1, 0, 0);
        check("R9 no slot", s_ready, 0);
        check("R7 stall", s_ready, 0);
        step(1, 2, 2, 0, 0, 0, 0);
        check("R7 table kept", s_a, keep);
        check("R10 ready", s_ready, 1);
        step(1, 0, 0, 5, 1, 0, 0);
        check("R10 no pop", s_ready, 0);

        // R8: release A, then release B with an allocation in the same cycle
        a_reg = pend.pop_front();
        step(0, 0, 0, 0, 0, 1, a_reg);
        b_reg = pend.pop_front();
        step(1, 0, 0, 5, 1, 1, b_reg);
        check("R8 ready", s_ready, 1);
        check("R8 alloc", s_dst, a_reg);
        step(1, 5, 0, 6, 1, 0, 0);
        check("R8 pushed", s_dst, b_reg);
        check("R4 r5", s_a, a_reg);
        check("R6 fifo", s_dst, b_reg);

        // random traffic with legal releases
        for (int n = 0; n < 3000; n++) begin
            bit rl;
            int rp;
            rl = (pend.size() != 0) && ($urandom_range(0, 2) != 0);
            rp = 0;
            if (rl) rp = pend.pop_front();
            step($urandom_range(0, 3) != 0, $urandom_range(0, 7), $urandom_range(0, 7),
                 $urandom_range(0, 7), $urandom_range(0, 4) != 0, rl, rp);
        end
        @(negedge clk);
        finish_run();
    end

endmodule